// File: doc/BRIEF.md
# Multi-Mode Timer with Capture

A 16-bit down-counting timer with two companion registers (reload/capture A and B), two sampled input pins and one driven pin. A three-bit mode code picks how the timer behaves and which events raise its two interrupt lines. In event-count mode the timer steps down on edges of pin A. In PWM mode it steps down on each instruction-cycle strobe and, on reaching zero, reloads from register A and register B in turn, optionally flipping an output pin on every reload. In capture mode it steps down on the strobe and copies its value into register A or B when pin A or pin B shows an edge of the chosen polarity.

Both input pins pass through a two-stage synchronizer, and edges are found only from the synchronized samples. The host reaches the block through a small register port: a write strobe with address and data, and a read address whose data appears on the next clock edge. The interrupt flags stay set until software writes 1 to them.

Top module: `multimode_timer`

## Requirements
- R1: After reset the counter, register A, register B and the control word read as 0, both interrupt lines are low and the driven pin is low. Addresses: 0 counter, 1 register A, 2 register B, 3 control. Control bits: [2:0] mode code, [3] run, [4] flag A, [5] flag B. A read returns the value addressed at the previous clock edge.
- R2: With code 000 the counter decrements once per rising edge of pin A, with code 001 once per falling edge; the opposite edge and the strobe input have no effect on it.
- R3: In event-count mode a decrement from 0 wraps the counter to 0xFFFF and sets flag A; a rising edge on pin B sets flag B.
- R4: In PWM mode (codes 100 and 101), a strobe that finds the counter at 0 loads register A or register B instead of decrementing, alternating, with register A first after any control write; an A reload sets flag A and a B reload sets flag B.
- R5: With code 101 the driven pin inverts on every PWM reload; with code 100 it holds its level.
- R6: Codes 010, 110, 011 and 111 select capture mode: the counter decrements once per strobe; pin A edges are rising for 010/110 and falling for 011/111; pin B edges are rising for 010/011 and falling for 110/111. A pin A edge copies the counter into register A and sets flag A; a pin B edge copies it into register B and sets flag B.
- R7: In capture mode a strobe that finds the counter at 0 wraps it to 0xFFFF and sets flag A.
- R8: Flags stay set until a control write with a 1 in the matching bit; a set event in the same cycle as that clear leaves the flag set. Each interrupt line equals its flag.
- R9: With the run bit at 0 the counter keeps its value apart from host writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Instruction-cycle strobe, one clock wide per count |
| pin_a_i | input | 1 | Asynchronous input pin A |
| pin_b_i | input | 1 | Asynchronous input pin B |
| pin_a_o | output | 1 | Driven pin, inverted on PWM reloads |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Registered read data |
| irq_a | output | 1 | Interrupt request A (flag A) |
| irq_b | output | 1 | Interrupt request B (flag B) |

## Verification
The properties assume the host does not rewrite the counter or register A in the same cycle as the event being checked, which is why each one excludes host writes in its antecedent. The stimulus holds each pin level for several clocks so that every transition survives the synchronizer as a single edge, and keeps the strobe low whenever a capture must see a known counter value. Random counter seeds, reload values and pulse counts are drawn so that the event-count tests never wrap unless wrap is the case under test.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

  typedef enum logic [1:0] {
    KIND_EVENT,
    KIND_PWM,
    KIND_CAPTURE
  } mmt_kind_e;

  typedef struct packed {
    mmt_kind_e kind;
    logic      a_fall;   // pin A edge is falling
    logic      b_fall;   // pin B edge is falling
    logic      toggle;   // PWM flips the driven pin
  } mmt_mode_t;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RA   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_RB   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd3;

  localparam int CTRL_RUN = 3;
  localparam int CTRL_FA  = 4;
  localparam int CTRL_FB  = 5;

  function automatic mmt_mode_t decode_mode(input logic [2:0] code);
    mmt_mode_t m;
    if (code[1])      m.kind = KIND_CAPTURE;
    else if (code[2]) m.kind = KIND_PWM;
    else              m.kind = KIND_EVENT;
    m.a_fall = code[0];
    m.b_fall = code[2];
    m.toggle = code[0];
    return m;
  endfunction

endpackage

// File: rtl/mmt_pin_sync.sv
// Synchronizer chain plus edge finder. STAGES must be at least 2.
module mmt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
  assign fall_o = ~chain_q[STAGES-1] & last_q;

endmodule

// File: rtl/mmt_irq_flag.sv
module mmt_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= set_i | (flag_o & ~clr_i);
  end

  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);                                           // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o);                              // R8

endmodule

// File: rtl/mmt_core.sv
module mmt_core
  import mmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  mmt_mode_t    mode_i,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         a_rise_i,
  input  logic         a_fall_i,
  input  logic         b_rise_i,
  input  logic         b_fall_i,
  input  logic         mode_wr_i,
  input  logic         cnt_wr_i,
  input  logic         ra_wr_i,
  input  logic         rb_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] ra_o,
  output logic [W-1:0] rb_o,
  output logic         pin_o,
  output logic         evt_a_o,
  output logic         evt_b_o
);
  logic [W-1:0] cnt_q, ra_q, rb_q;
  logic         phase_b_q, pin_q;

  logic is_event, is_pwm, is_cap;
  logic a_edge, b_edge, count_en, at_zero, reload, wrap, cap_a, cap_b;

  always_comb begin
    is_event = (mode_i.kind == KIND_EVENT);
    is_pwm   = (mode_i.kind == KIND_PWM);
    is_cap   = (mode_i.kind == KIND_CAPTURE);
    a_edge   = mode_i.a_fall ? a_fall_i : a_rise_i;
    b_edge   = mode_i.b_fall ? b_fall_i : b_rise_i;
    count_en = run_i & (is_event ? a_edge : tick_i);
    at_zero  = (cnt_q == '0);
    reload   = is_pwm & count_en & at_zero;
    wrap     = ~is_pwm & count_en & at_zero;
    cap_a    = is_cap & a_edge;
    cap_b    = is_cap & b_edge;
    evt_a_o  = wrap | (reload & ~phase_b_q) | cap_a;
    evt_b_o  = (reload & phase_b_q) | cap_b | (is_event & b_rise_i);
  end

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (cnt_wr_i) cnt_q <= wdata_i;
    else if (reload)   cnt_q <= phase_b_q ? rb_q : ra_q;
    else if (count_en) cnt_q <= cnt_q - W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)            phase_b_q <= 1'b0;
    else if (reload)    phase_b_q <= ~phase_b_q;
    else if (mode_wr_i) phase_b_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)          ra_q <= '0;
    else if (cap_a)   ra_q <= cnt_q;
    else if (ra_wr_i) ra_q <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst)          rb_q <= '0;
    else if (cap_b)   rb_q <= cnt_q;
    else if (rb_wr_i) rb_q <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst)                         pin_q <= 1'b0;
    else if (reload && mode_i.toggle) pin_q <= ~pin_q;
  end

  assign cnt_o = cnt_q;
  assign ra_o  = ra_q;
  assign rb_o  = rb_q;
  assign pin_o = pin_q;

  AST_RUN_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !cnt_wr_i) |=> $stable(cnt_q));                   // R9
  AST_PWM_FIRST_A: assert property (@(posedge clk) disable iff (rst)
    (reload && !phase_b_q && !cnt_wr_i && !ra_wr_i) |=> (cnt_q == ra_q && phase_b_q)); // R4
  AST_WRAP_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    (wrap && !cnt_wr_i) |=> (&cnt_q));                           // R7
  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(reload && mode_i.toggle) |=> $stable(pin_q));              // R5
  AST_CAPTURE_A: assert property (@(posedge clk) disable iff (rst)
    cap_a |=> (ra_q == $past(cnt_q)));                           // R6

endmodule

// File: rtl/multimode_timer.sv
module multimode_timer
  import mmt_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              pin_a_i,
  input  logic              pin_b_i,
  output logic              pin_a_o,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  output logic              irq_a,
  output logic              irq_b
);
  localparam int CTRL_USED = CTRL_FB + 1;

  logic [2:0]   mode_q;
  logic         run_q;
  mmt_mode_t    mode_dec;
  logic         mode_wr, cnt_wr, ra_wr, rb_wr;
  logic         a_rise, a_fall, b_rise, b_fall;
  logic [W-1:0] cnt_v, ra_v, rb_v;
  logic         evt_a, evt_b, flag_a, flag_b;
  logic [CTRL_USED-1:0] ctrl_v;

  assign mode_wr  = wr_en && (wr_addr == ADDR_CTRL);
  assign cnt_wr   = wr_en && (wr_addr == ADDR_CNT);
  assign ra_wr    = wr_en && (wr_addr == ADDR_RA);
  assign rb_wr    = wr_en && (wr_addr == ADDR_RB);
  assign mode_dec = decode_mode(mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 3'b000;
      run_q  <= 1'b0;
    end else if (mode_wr) begin
      mode_q <= wr_data[2:0];
      run_q  <= wr_data[CTRL_RUN];
    end
  end

  mmt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst(rst), .pin_i(pin_a_i), .rise_o(a_rise), .fall_o(a_fall));
  mmt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst(rst), .pin_i(pin_b_i), .rise_o(b_rise), .fall_o(b_fall));

  mmt_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .mode_i(mode_dec), .run_i(run_q), .tick_i(tick),
    .a_rise_i(a_rise), .a_fall_i(a_fall), .b_rise_i(b_rise), .b_fall_i(b_fall),
    .mode_wr_i(mode_wr), .cnt_wr_i(cnt_wr), .ra_wr_i(ra_wr), .rb_wr_i(rb_wr),
    .wdata_i(wr_data), .cnt_o(cnt_v), .ra_o(ra_v), .rb_o(rb_v),
    .pin_o(pin_a_o), .evt_a_o(evt_a), .evt_b_o(evt_b));

  mmt_irq_flag u_flag_a (
    .clk(clk), .rst(rst), .set_i(evt_a),
    .clr_i(mode_wr && wr_data[CTRL_FA]), .flag_o(flag_a));
  mmt_irq_flag u_flag_b (
    .clk(clk), .rst(rst), .set_i(evt_b),
    .clr_i(mode_wr && wr_data[CTRL_FB]), .flag_o(flag_b));

  assign irq_a  = flag_a;
  assign irq_b  = flag_b;
  assign ctrl_v = {flag_b, flag_a, run_q, mode_q};

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        ADDR_CNT: rd_data <= cnt_v;
        ADDR_RA:  rd_data <= ra_v;
        ADDR_RB:  rd_data <= rb_v;
        default:  rd_data <= W'(ctrl_v);
      endcase
    end
  end

  AST_IRQ_LOW_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
    (!evt_a && !irq_a) |=> !irq_a);                              // R8

endmodule

// File: tb/multimode_timer_bench.sv
module multimode_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, tick, pin_a_i, pin_b_i, wr_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [15:0] wr_data;
  logic        pin_a_o, irq_a, irq_b;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  multimode_timer u_multimode_timer (
    .clk(clk), .rst(rst), .tick(tick), .pin_a_i(pin_a_i), .pin_b_i(pin_b_i),
    .pin_a_o(pin_a_o), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_a(irq_a), .irq_b(irq_b));

  function automatic logic [15:0] ctl(input logic [2:0] code, input bit run, input logic [1:0] clr);
    return {10'd0, clr[1], clr[0], run, code};
  endfunction

  function automatic void pwm_model(input int ra, input int rb, input int t, input bit tog,
                                    input bit p0, output int c, output bit pin,
                                    output bit fa, output bit fb);
    bit ph = 1'b0;
    c = 0; pin = p0; fa = 1'b0; fb = 1'b0;
    for (int i = 0; i < t; i++) begin
      if (c == 0) begin
        if (!ph) begin c = ra; fa = 1'b1; end
        else     begin c = rb; fb = 1'b1; end
        ph = ~ph;
        if (tog) pin = ~pin;
      end else c = c - 1;
    end
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic set_pin(input bit is_b, input logic lvl, input bit jitter);
    @(negedge clk);
    if (is_b) pin_b_i = lvl; else pin_a_i = lvl;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (jitter) tick = 1'($urandom % 2);
    end
    tick = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, n, x, y;
    int k, ra, rb, t, c;
    bit pin, fa, fb, p0;
    logic [2:0] code;
    logic [2:0] caps [4] = '{3'b010, 3'b110, 3'b011, 3'b111};

    void'($urandom(32'd4711));
    rst = 1'b1; tick = 1'b0; pin_a_i = 1'b0; pin_b_i = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); check("R1 reg after reset", v, 16'h0);
    end
    check("R1 irq_a", {15'd0, irq_a}, 16'd0);
    check("R1 irq_b", {15'd0, irq_b}, 16'd0);
    check("R1 pin_a_o", {15'd0, pin_a_o}, 16'd0);

    // R2 event mode, rising edges, random pulse counts, strobe jitter ignored
    for (int it = 0; it < 3; it++) begin
      n = 16'(100 + $urandom % 1000);
      k = 1 + int'($urandom % 5);
      wr(2'd3, ctl(3'b000, 1'b1, 2'b11));
      wr(2'd0, n);
      for (int p = 0; p < k; p++) begin
        set_pin(1'b0, 1'b1, 1'b1);
        set_pin(1'b0, 1'b0, 1'b1);
      end
      rd(2'd0, v); check("R2 rising pulse count", v, n - 16'(k));
    end
    wr(2'd0, 16'd50);
    set_pin(1'b0, 1'b1, 1'b1); rd(2'd0, v); check("R2 code 000 rise counts", v, 16'd49);
    set_pin(1'b0, 1'b0, 1'b1); rd(2'd0, v); check("R2 code 000 fall ignored", v, 16'd49);
    wr(2'd3, ctl(3'b001, 1'b1, 2'b11));
    wr(2'd0, 16'd50);
    set_pin(1'b0, 1'b1, 1'b1); rd(2'd0, v); check("R2 code 001 rise ignored", v, 16'd50);
    set_pin(1'b0, 1'b0, 1'b1); rd(2'd0, v); check("R2 code 001 fall counts", v, 16'd49);

    // R3 event underflow wrap and pin B flag
    wr(2'd3, ctl(3'b000, 1'b1, 2'b11));
    wr(2'd0, 16'd1);
    for (int p = 0; p < 2; p++) begin
      set_pin(1'b0, 1'b1, 1'b0); set_pin(1'b0, 1'b0, 1'b0);
    end
    rd(2'd0, v); check("R3 wrap value", v, 16'hFFFF);
    check("R3 flag A on wrap", {15'd0, irq_a}, 16'd1);
    check("R3 flag B before pin B", {15'd0, irq_b}, 16'd0);
    set_pin(1'b1, 1'b1, 1'b0);
    check("R3 flag B on pin B rise", {15'd0, irq_b}, 16'd1);
    set_pin(1'b1, 1'b0, 1'b0);

    // R8 write-one-to-clear per bit
    wr(2'd3, ctl(3'b000, 1'b1, 2'b01));
    check("R8 flag A cleared", {15'd0, irq_a}, 16'd0);
    check("R8 flag B kept", {15'd0, irq_b}, 16'd1);
    rd(2'd3, v); check("R8 control readback", v, 16'h0028);
    wr(2'd3, ctl(3'b000, 1'b1, 2'b10));
    check("R8 flag B cleared", {15'd0, irq_b}, 16'd0);

    // R9 run bit clear freezes event counting
    wr(2'd3, ctl(3'b000, 1'b0, 2'b11));
    wr(2'd0, 16'd20);
    set_pin(1'b0, 1'b1, 1'b0); set_pin(1'b0, 1'b0, 1'b0);
    rd(2'd0, v); check("R9 event frozen", v, 16'd20);

    // R4 R5 PWM with random reload values and lengths
    for (int it = 0; it < 4; it++) begin
      ra = 2 + int'($urandom % 6);
      rb = 2 + int'($urandom % 6);
      t  = 5 + int'($urandom % 30);
      wr(2'd1, 16'(ra));
      wr(2'd2, 16'(rb));
      wr(2'd3, ctl({2'b10, 1'(it % 2)}, 1'b1, 2'b11));
      wr(2'd0, 16'd0);
      p0 = pin_a_o;
      run_ticks(t);
      pwm_model(ra, rb, t, 1'(it % 2), p0, c, pin, fa, fb);
      rd(2'd0, v); check("R4 PWM counter", v, 16'(c));
      check("R4 PWM flag A", {15'd0, irq_a}, {15'd0, fa});
      check("R4 PWM flag B", {15'd0, irq_b}, {15'd0, fb});
      check("R5 PWM pin", {15'd0, pin_a_o}, {15'd0, pin});
    end

    // R8 set wins over clear in the same cycle (PWM reload from A)
    wr(2'd1, 16'd7);
    wr(2'd3, ctl(3'b101, 1'b1, 2'b11));
    wr(2'd0, 16'd0);
    p0 = pin_a_o;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = ctl(3'b101, 1'b1, 2'b01); tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    check("R8 set wins over clear", {15'd0, irq_a}, 16'd1);
    check("R5 pin toggled on reload", {15'd0, pin_a_o}, {15'd0, ~p0});
    rd(2'd0, v); check("R4 first reload from A", v, 16'd7);

    // R6 capture polarity for all four codes
    for (int it = 0; it < 4; it++) begin
      code = caps[it];
      wr(2'd3, ctl(code, 1'b1, 2'b11));
      wr(2'd1, 16'h1234);
      wr(2'd2, 16'h5678);
      x = 16'($urandom); y = x ^ 16'h00FF;
      wr(2'd0, x);
      set_pin(1'b0, 1'b1, 1'b0);
      set_pin(1'b1, 1'b1, 1'b0);
      wr(2'd0, y);
      set_pin(1'b0, 1'b0, 1'b0);
      set_pin(1'b1, 1'b0, 1'b0);
      rd(2'd1, v); check("R6 capture A", v, code[0] ? y : x);
      rd(2'd2, v); check("R6 capture B", v, code[2] ? y : x);
      check("R6 capture flag A", {15'd0, irq_a}, 16'd1);
      check("R6 capture flag B", {15'd0, irq_b}, 16'd1);
    end

    // R6 capture counts strobes
    wr(2'd3, ctl(3'b010, 1'b1, 2'b11));
    x = 16'(1000 + $urandom % 1000);
    t = 3 + int'($urandom % 40);
    wr(2'd0, x);
    run_ticks(t);
    rd(2'd0, v); check("R6 strobe count", v, x - 16'(t));

    // R7 capture underflow
    wr(2'd3, ctl(3'b010, 1'b1, 2'b11));
    wr(2'd0, 16'd0);
    run_ticks(1);
    rd(2'd0, v); check("R7 capture wrap", v, 16'hFFFF);
    check("R7 flag A on wrap", {15'd0, irq_a}, 16'd1);

    // R9 capture mode with run clear
    wr(2'd3, ctl(3'b010, 1'b0, 2'b11));
    wr(2'd0, 16'd500);
    run_ticks(10);
    rd(2'd0, v); check("R9 capture frozen", v, 16'd500);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule